// File: doc/BRIEF.md
# Eight-Level Interrupt Controller Command Logic

This block is the core of an eight-input programmable interrupt controller. It watches eight level-sensitive request lines and holds three registers: pending requests, in-service levels and a mask. It resolves priority among unmasked requests on a rotating ring and raises one interrupt line toward a processor. When the processor acknowledges, the block moves the winning level from pending to in-service and returns that level number on its read data.

Software first runs a short two-write setup sequence. After that, it steers the block with run-time command bytes. A byte on address 1 replaces the mask. Bytes on address 0 end service of a level, either the highest-priority level in service or a named level, and can optionally rotate the priority ring at the same time. Address-0 bytes also set the lowest-priority level directly and switch a special mask mode on or off. In special mask mode, a level that is in service no longer holds back lower-priority requests.

Top module: `irq_cmd_ctrl`

## Requirements
- R1: A write with `addr`=0 and `wdata[4]`=1 starts setup. It clears the pending, in-service and mask registers, makes level 7 the lowest priority and turns special mask mode off. The next write with `addr`=1 completes setup, and its data is ignored. Until setup completes, `int_o` stays low, request lines are not recorded, acknowledges do not change `rdata`, and all other writes have no effect.
- R2: After setup, a write with `addr`=1 loads all eight bits of the mask from `wdata`. Bit n set to 1 inhibits request line n. Bit n set to 0 enables it.
- R3: After setup, a write with `addr`=0 is decoded on `wdata[4:3]`. The value 00 is an end-of-interrupt/priority command and 01 is a mask-mode command.
- R4: Request lines are sampled every clock, and `int_o` follows one cycle after a line changes. Priority runs on a ring: the level after the lowest-priority level is the highest. After reset and setup, level 0 is the highest priority. In normal mode, `int_o` is high only when the highest-priority unmasked pending level outranks every level in service.
- R5: An acknowledge while `int_o` is high clears the winning pending bit for one cycle, sets the matching in-service bit and loads `rdata` with {5'b0, level}. An acknowledge while `int_o` is low loads `rdata` with 8'h07 and changes no other state.
- R6: A command byte with bits 7:5 = 001 clears the highest-priority set in-service bit.
- R7: A command byte with bits 7:5 = 011 clears the in-service bit named by bits 2:0.
- R8: Bits 7:5 = 101 behaves as in R6 and also makes the cleared level the lowest priority. Bits 7:5 = 111 behaves as in R7 and also makes the named level the lowest priority.
- R9: Bits 7:5 = 110 makes the level in bits 2:0 the lowest priority, without ending any service. Codes 000, 010 and 100 have no effect.
- R10: A mask-mode byte with bit 6 = 1 loads special mask mode from bit 5. In special mask mode, any unmasked pending level whose own in-service bit is clear raises `int_o`.
- R11: A mask-mode byte with bit 6 = 0 leaves the current mask mode unchanged, whatever bit 5 holds.
- R12: After reset, `int_o` is 0, `rdata` is 0 and the block waits for setup.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr | input | 1 | Write strobe for one cycle |
| addr | input | 1 | Command address bit |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Level returned by the last acknowledge |
| irq_in | input | 8 | Level request lines, bit n is level n |
| int_o | output | 1 | Interrupt request to the processor |
| ack | input | 1 | Acknowledge strobe for one cycle |

## Verification
A wrong in-service register shows up only indirectly: either `int_o` stays low when a request should nest, or a lower level breaks through. The bench therefore follows every end-of-interrupt with a request chosen so that a wrongly cleared bit flips `int_o` on the very next cycle. A wrong priority pointer is exposed through `rdata` on the next acknowledge, using request pairs whose winner differs under each candidate rotation. A mask-mode flag that drifts is caught within one cycle, because a lower level is held pending behind an in-service level, so the flag is the only thing that decides `int_o`.

// File: rtl/irq_cmd_ctrl.sv
module irq_cmd_ctrl (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr,
  input  logic       addr,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  input  logic [7:0] irq_in,
  output logic       int_o,
  input  logic       ack
);
  typedef enum logic [1:0] {S_IDLE, S_WAIT, S_RUN} st_t;

  st_t        st;
  logic [7:0] irr, isr, imr;
  logic [2:0] low;
  logic       smm;

  wire run   = (st == S_RUN);
  wire start = wr && !addr && wdata[4];
  wire cmd_a = run && wr && !addr && (wdata[4:3] == 2'b00);
  wire cmd_b = run && wr && !addr && (wdata[4:3] == 2'b01);
  wire cmd_m = run && wr && addr;

  // returns {found, level} of the highest-priority set bit
  function automatic logic [3:0] pick(input logic [7:0] v, input logic [2:0] lo);
    logic [3:0] r;
    logic [2:0] idx;
    r = 4'b0;
    for (int k = 7; k >= 0; k--) begin
      idx = lo + 3'(k) + 3'd1;
      if (v[idx]) r = {1'b1, idx};
    end
    return r;
  endfunction

  logic [7:0] cand;
  logic [3:0] wsel, isel;
  assign cand = irr & ~imr & (smm ? ~isr : 8'hFF);
  assign wsel = pick(cand, low);
  assign isel = pick(isr, low);

  wire [2:0] wrank = wsel[2:0] - low - 3'd1;
  wire [2:0] irank = isel[2:0] - low - 3'd1;
  wire       win   = run && wsel[3] && (smm || !isel[3] || (wrank < irank));
  wire       take  = run && ack && win;
  wire [7:0] won   = take ? (8'd1 << wsel[2:0]) : 8'd0;

  assign int_o = win;

  wire [2:0] op  = wdata[7:5];
  wire [2:0] lvl = wdata[2:0];
  logic [7:0] clr;
  logic       setlow;
  logic [2:0] newlow;

  always_comb begin
    clr    = 8'd0;
    setlow = 1'b0;
    newlow = low;
    if (cmd_a) begin
      case (op)
        3'b001: if (isel[3]) clr[isel[2:0]] = 1'b1;
        3'b011: clr[lvl] = 1'b1;
        3'b101: if (isel[3]) begin
                  clr[isel[2:0]] = 1'b1;
                  setlow = 1'b1;
                  newlow = isel[2:0];
                end
        3'b111: begin clr[lvl] = 1'b1; setlow = 1'b1; newlow = lvl; end
        3'b110: begin setlow = 1'b1; newlow = lvl; end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= S_IDLE;
      irr   <= 8'd0;
      isr   <= 8'd0;
      imr   <= 8'd0;
      low   <= 3'd7;
      smm   <= 1'b0;
      rdata <= 8'd0;
    end else if (start) begin
      st  <= S_WAIT;
      irr <= 8'd0;
      isr <= 8'd0;
      imr <= 8'd0;
      low <= 3'd7;
      smm <= 1'b0;
    end else begin
      if (st == S_WAIT && wr && addr) st <= S_RUN;
      if (run) irr <= irq_in & ~won;
      isr <= (isr & ~clr) | won;
      if (cmd_m) imr <= wdata;
      if (setlow) low <= newlow;
      if (cmd_b && wdata[6]) smm <= wdata[5];
      if (run && ack) rdata <= take ? {5'd0, wsel[2:0]} : 8'h07;
    end
  end

  p_idle_no_pending_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> (irr == 8'd0));
  p_mask_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_m && !start) |=> (imr == $past(wdata)));
  p_int_unmasked_r4: assert property (@(posedge clk) disable iff (!rst_n)
    int_o |-> ((irr & ~imr) != 8'd0));
  p_ack_in_service_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !cmd_a) |=> (isr[$past(wsel[2:0])] && rdata[2:0] == $past(wsel[2:0])));
  p_eoi_no_growth_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_a && !ack) |=> ($countones(isr) <= $countones($past(isr))));
  p_mode_kept_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_b && !wdata[6]) |=> (smm == $past(smm)));
endmodule

// File: tb/tb_irq_cmd_ctrl.sv
module tb_irq_cmd_ctrl;
  logic clk = 1'b0, rst_n = 1'b0, wr = 1'b0, addr = 1'b0, ack = 1'b0;
  logic [7:0] wdata = 8'd0, irq_in = 8'd0, rdata;
  logic int_o;

  irq_cmd_ctrl dut (.clk(clk), .rst_n(rst_n), .wr(wr), .addr(addr), .wdata(wdata),
                    .rdata(rdata), .irq_in(irq_in), .int_o(int_o), .ack(ack));

  always #2 clk = ~clk;

  typedef struct {
    string      tag;
    bit         exp_int;
    bit         use_rd;
    logic [7:0] exp_rd;
  } item_t;

  item_t q[$];
  int total = 0, bad = 0;
  bit done = 1'b0;

  task automatic expect_io(string tag, bit ei, bit ur, logic [7:0] er);
    item_t it;
    it.tag = tag; it.exp_int = ei; it.use_rd = ur; it.exp_rd = er;
    q.push_back(it);
    #0;
  endtask

  initial begin
    item_t it;
    forever begin
      wait (q.size() > 0);
      it = q.pop_front();
      total++;
      if (int_o !== it.exp_int) begin
        bad++;
        $display("FAIL %s int_o actual=%0b expected=%0b", it.tag, int_o, it.exp_int);
      end
      if (it.use_rd) begin
        total++;
        if (rdata !== it.exp_rd) begin
          bad++;
          $display("FAIL %s rdata actual=%02h expected=%02h", it.tag, rdata, it.exp_rd);
        end
      end
    end
  end

  task automatic tick(); @(negedge clk); endtask
  task automatic wr_cmd(input logic a, input logic [7:0] d);
    addr = a; wdata = d; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
  endtask
  task automatic setreq(input logic [7:0] v); irq_in = v; @(negedge clk); endtask
  task automatic do_ack(); ack = 1'b1; @(negedge clk); ack = 1'b0; endtask

  initial begin
    #(4 * 200000);
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    expect_io("R12 reset state", 1'b0, 1'b1, 8'h00);
    rst_n = 1'b1;
    tick();
    // before setup
    setreq(8'h01); tick();
    expect_io("R1 no interrupt before setup", 1'b0, 1'b0, 8'h00);
    do_ack();
    expect_io("R1 ack ignored before setup", 1'b0, 1'b1, 8'h00);
    wr_cmd(1'b1, 8'hFF);
    wr_cmd(1'b0, 8'h10);
    wr_cmd(1'b1, 8'h01);
    tick();
    expect_io("R1 setup done, early mask write ignored", 1'b1, 1'b0, 8'h00);
    // mask
    wr_cmd(1'b1, 8'h01);
    expect_io("R2 line 0 masked", 1'b0, 1'b0, 8'h00);
    wr_cmd(1'b1, 8'hFE);
    expect_io("R2 other lines masked only", 1'b1, 1'b0, 8'h00);
    wr_cmd(1'b1, 8'h00);
    // priority and acknowledge
    setreq(8'h0A);
    expect_io("R4 request pending", 1'b1, 1'b0, 8'h00);
    do_ack();
    expect_io("R5 ack returns level 1", 1'b0, 1'b1, 8'h01);
    tick();
    expect_io("R4 lower and equal blocked", 1'b0, 1'b0, 8'h00);
    wr_cmd(1'b0, 8'h20);
    expect_io("R6 R3 nonspecific eoi frees level 1", 1'b1, 1'b0, 8'h00);
    setreq(8'h08);
    do_ack();
    expect_io("R5 ack returns level 3", 1'b0, 1'b1, 8'h03);
    setreq(8'h02);
    expect_io("R4 higher level nests", 1'b1, 1'b0, 8'h00);
    do_ack();
    expect_io("R5 nested ack level 1", 1'b0, 1'b1, 8'h01);
    setreq(8'h00);
    wr_cmd(1'b0, 8'h20);
    setreq(8'h04);
    expect_io("R6 eoi cleared top level only", 1'b1, 1'b0, 8'h00);
    setreq(8'h10);
    expect_io("R4 level 4 blocked by level 3", 1'b0, 1'b0, 8'h00);
    wr_cmd(1'b0, 8'h63);
    expect_io("R7 specific eoi level 3", 1'b1, 1'b0, 8'h00);
    do_ack();
    expect_io("R5 ack returns level 4", 1'b0, 1'b1, 8'h04);
    setreq(8'h00);
    wr_cmd(1'b0, 8'h64);
    // rotation
    wr_cmd(1'b0, 8'hC2);
    setreq(8'h12);
    do_ack();
    expect_io("R9 set lowest 2 picks level 4", 1'b0, 1'b1, 8'h04);
    wr_cmd(1'b0, 8'hA0);
    expect_io("R8 rotate eoi frees level 4", 1'b1, 1'b0, 8'h00);
    do_ack();
    expect_io("R8 rotated ring picks level 1", 1'b0, 1'b1, 8'h01);
    wr_cmd(1'b0, 8'hE1);
    setreq(8'h03);
    do_ack();
    expect_io("R8 specific rotate picks level 0", 1'b0, 1'b1, 8'h00);
    wr_cmd(1'b0, 8'h60);
    wr_cmd(1'b0, 8'hC7);
    setreq(8'h00);
    // special mask mode
    setreq(8'h04);
    do_ack();
    expect_io("R5 ack returns level 2", 1'b0, 1'b1, 8'h02);
    setreq(8'h0C);
    expect_io("R4 level 3 blocked in normal mode", 1'b0, 1'b0, 8'h00);
    wr_cmd(1'b0, 8'h68);
    expect_io("R10 R3 special mask lets level 3 through", 1'b1, 1'b0, 8'h00);
    wr_cmd(1'b0, 8'h08);
    expect_io("R11 enable bit clear keeps mode", 1'b1, 1'b0, 8'h00);
    wr_cmd(1'b0, 8'h48);
    expect_io("R10 back to normal mode", 1'b0, 1'b0, 8'h00);
    do_ack();
    expect_io("R5 ack with no winner gives 7", 1'b0, 1'b1, 8'h07);
    wr_cmd(1'b0, 8'h00);
    expect_io("R9 code 000 no effect", 1'b0, 1'b0, 8'h00);
    wr_cmd(1'b0, 8'h80);
    expect_io("R9 code 100 no effect", 1'b0, 1'b0, 8'h00);
    wr_cmd(1'b0, 8'h20);
    expect_io("R6 eoi after spurious ack", 1'b1, 1'b0, 8'h00);
    do_ack();
    expect_io("R5 level 2 served again", 1'b0, 1'b1, 8'h02);
    // restart setup
    setreq(8'h01);
    wr_cmd(1'b0, 8'h10);
    expect_io("R1 restart blocks interrupt", 1'b0, 1'b0, 8'h00);
    wr_cmd(1'b1, 8'h00);
    tick();
    expect_io("R1 restart completes, level 0 wins", 1'b1, 1'b0, 8'h00);
    tick();
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule